// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block converts one pulse-width command into enables for the high-side and low-side switches of a synchronous buck half-bridge. It never turns a switch on on a timer alone. The high-side enable waits until the low-side gate is seen to have discharged. The low-side enable waits until the switch node is seen to have collapsed. As a fallback, the low side is forced on after a bounded wait so that the bootstrap supply stays charged. If the switch node then stays high for too long, the block drops both gates and holds them low until the command next rises.

The command arrives as two comparator flags: one means "above the upper threshold" and the other means "below the lower threshold". When neither flag is set, the command sits in a middle window. If it stays there for a holdoff period, both gates are parked low. All five incoming flags are asynchronous. Each passes through a two-flop synchronizer before the state machine uses it. A supply-good flag, with hysteresis already applied outside the block, gates the whole sequence.

The state machine has eight states:
- OFF: supply not yet good.
- UP_WAIT: low side removed, waiting for the low gate to fall.
- UP_ON: high side on.
- DN_WAIT: high side removed, waiting for the switch node to fall.
- DN_ON: low side on after the switch node fell.
- DN_FORCED: low side forced on after the timeout.
- SHUT: middle-window shutdown.
- FAULT: both gates held low after the switch node stayed high.

The named transitions are:
- OFF to UP_WAIT or DN_WAIT when the supply is good.
- UP_WAIT to UP_ON on the low-gate flag.
- DN_WAIT to DN_ON on the switch-node flag.
- DN_WAIT to DN_FORCED on timeout.
- DN_FORCED to DN_ON on the switch-node flag.
- DN_FORCED to FAULT on the fault timer.
- Any state except FAULT to SHUT after the holdoff.
- SHUT or FAULT to UP_WAIT on a high command.
- SHUT to DN_WAIT on a low command.
- Any state to OFF on supply loss.
- Reversal: UP_WAIT or UP_ON to DN_WAIT, and DN_WAIT, DN_ON or DN_FORCED to UP_WAIT.

Top module: `hb_deadtime_seq`

## Requirements
- R1: While the supply-good flag is 0, both enables are 0 and the status reads 0 (off). Once the supply becomes good, the command takes control. A later supply loss returns the block to off.
- R2: When the command goes high, the low-side enable drops first. The high-side enable rises only in the cycle after the synchronized low-gate-discharged flag is seen as 1.
- R3: When the command goes low, the high-side enable drops first. The low-side enable rises after the synchronized switch-node-low flag is seen as 1.
- R4: If the switch-node flag has not arrived after TMO_CYC cycles in DN_WAIT, the low-side enable is raised anyway (DN_FORCED, status 2).
- R5: After DN_FORCED has run for FLT_CYC cycles with the switch node still high, the block enters FAULT (status 5) with both enables 0. While in FAULT, a low command, a middle-window command and a recovering switch node are all ignored. Only a high command leaves FAULT.
- R6: Command encoding: above=1 with below=0 is high; below=1 with above=0 is low; any other combination is the middle window. A middle window that lasts HOLD_CYC synchronized cycles enters SHUT (status 4) with both enables 0. A shorter window leaves the gates unchanged.
- R7: SHUT ends as soon as the command leaves the window. A high command resumes through UP_WAIT and a low command resumes through DN_WAIT.
- R8: If the command reverses before a pending turn-on is released, that turn-on is abandoned and the sequence for the new direction begins.
- R9: The two enables are never 1 in the same cycle. Each enable rises only when the other was already 0 in the previous cycle.
- R10: Status codes are 0 off, 1 upper on, 2 lower on, 3 waiting (either direction), 4 shutdown and 5 fault. An input change reaches the state register on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_hi | input | 1 | Command is above the upper threshold |
| pwm_below_lo | input | 1 | Command is below the lower threshold |
| lgate_low | input | 1 | Low-side gate voltage is below its threshold |
| swnode_low | input | 1 | Switch-node voltage is below its threshold |
| supply_ok | input | 1 | Supply good, hysteresis already applied |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| seq_status | output | 3 | Current state code (see R10) |

## Verification
The assertions check the following on every cycle:
- The two enables never overlap.
- There is at least one dead cycle before either enable rises.
- The high side rises only after the low-gate flag has been seen.
- The supply-loss forcing behaves as required.
- FAULT persists until a high command arrives.

The exact cycle counts can only be shown by the bench's sweeps:
- the three-edge latency;
- the timeout edge as the switch-node flag is delayed across the timeout;
- the holdoff boundary for every window length around HOLD_CYC;
- the fault entry point and the behaviour of reversals.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_UP_WAIT   = 3'd1,
        ST_UP_ON     = 3'd2,
        ST_DN_WAIT   = 3'd3,
        ST_DN_ON     = 3'd4,
        ST_DN_FORCED = 3'd5,
        ST_SHUT      = 3'd6,
        ST_FAULT     = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_HIGH = 2'd1,
        LV_MID  = 2'd2
    } pwm_lvl_e;

    localparam logic [2:0] STAT_OFF   = 3'd0;
    localparam logic [2:0] STAT_UPPER = 3'd1;
    localparam logic [2:0] STAT_LOWER = 3'd2;
    localparam logic [2:0] STAT_WAIT  = 3'd3;
    localparam logic [2:0] STAT_SHUT  = 3'd4;
    localparam logic [2:0] STAT_FAULT = 3'd5;

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hbd_count.sv
module hbd_count #(
    parameter int WIDTH = 4,
    parameter int LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [WIDTH-1:0] cnt
);
    localparam logic [WIDTH-1:0] LIM = WIDTH'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (cnt < LIM) cnt <= cnt + WIDTH'(1);
    end
endmodule

// File: rtl/hbd_fsm.sv
module hbd_fsm
    import hbd_pkg::*;
#(
    parameter int TMO_CYC  = 32,
    parameter int FLT_CYC  = 250,
    parameter int HOLD_CYC = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       above_s,
    input  logic       below_s,
    input  logic       lg_low_s,
    input  logic       sw_low_s,
    input  logic       sup_s,
    output logic       hs_en,
    output logic       ls_en,
    output logic [2:0] status
);
    localparam int MAXC = (TMO_CYC > FLT_CYC) ? TMO_CYC : FLT_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam int HW   = $clog2(HOLD_CYC + 1);
    localparam logic [TW-1:0] TMO_M1  = TW'(TMO_CYC - 1);
    localparam logic [TW-1:0] FLT_M1  = TW'(FLT_CYC - 1);
    localparam logic [HW-1:0] HOLD_M1 = HW'(HOLD_CYC - 1);

    seq_state_e state_q, state_d;
    pwm_lvl_e   lvl;
    logic [TW-1:0] tmr;
    logic [HW-1:0] mid_cnt;
    logic          hold_done;

    always_comb begin
        if (above_s && !below_s)      lvl = LV_HIGH;
        else if (below_s && !above_s) lvl = LV_LOW;
        else                          lvl = LV_MID;
    end

    hbd_count #(.WIDTH(TW), .LIMIT(MAXC - 1)) u_state_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(tmr)
    );

    hbd_count #(.WIDTH(HW), .LIMIT(HOLD_CYC - 1)) u_mid_tmr (
        .clk(clk), .rst_n(rst_n), .clr(lvl != LV_MID), .cnt(mid_cnt)
    );

    assign hold_done = (lvl == LV_MID) && (mid_cnt == HOLD_M1);

    always_comb begin
        state_d = state_q;
        if (!sup_s) begin
            state_d = ST_OFF;
        end else if (state_q == ST_FAULT) begin
            if (lvl == LV_HIGH) state_d = ST_UP_WAIT;
        end else if (hold_done) begin
            state_d = ST_SHUT;
        end else begin
            unique case (state_q)
                ST_OFF, ST_SHUT: begin
                    if (lvl == LV_HIGH)     state_d = ST_UP_WAIT;
                    else if (lvl == LV_LOW) state_d = ST_DN_WAIT;
                end
                ST_UP_WAIT: begin
                    if (lvl == LV_LOW)        state_d = ST_DN_WAIT;
                    else if (lvl == LV_HIGH && lg_low_s) state_d = ST_UP_ON;
                end
                ST_UP_ON: begin
                    if (lvl == LV_LOW) state_d = ST_DN_WAIT;
                end
                ST_DN_WAIT: begin
                    if (lvl == LV_HIGH)                   state_d = ST_UP_WAIT;
                    else if (lvl == LV_LOW && sw_low_s)   state_d = ST_DN_ON;
                    else if (lvl == LV_LOW && tmr >= TMO_M1) state_d = ST_DN_FORCED;
                end
                ST_DN_ON: begin
                    if (lvl == LV_HIGH) state_d = ST_UP_WAIT;
                end
                ST_DN_FORCED: begin
                    if (lvl == LV_HIGH)     state_d = ST_UP_WAIT;
                    else if (sw_low_s)      state_d = ST_DN_ON;
                    else if (tmr >= FLT_M1) state_d = ST_FAULT;
                end
                ST_FAULT: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        hs_en  = 1'b0;
        ls_en  = 1'b0;
        status = STAT_OFF;
        unique case (state_q)
            ST_OFF:       status = STAT_OFF;
            ST_UP_WAIT,
            ST_DN_WAIT:   status = STAT_WAIT;
            ST_UP_ON:     begin hs_en = 1'b1; status = STAT_UPPER; end
            ST_DN_ON,
            ST_DN_FORCED: begin ls_en = 1'b1; status = STAT_LOWER; end
            ST_SHUT:      status = STAT_SHUT;
            ST_FAULT:     status = STAT_FAULT;
        endcase
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));
    // R9
    hs_deadband_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!ls_en));
    // R9
    ls_deadband_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(!hs_en));
    // R2
    hs_after_lg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(lg_low_s));
    // R1
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!hs_en && !ls_en && status == STAT_OFF));
    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && sup_s && lvl != LV_HIGH) |=> (status == STAT_FAULT));
endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq #(
    parameter int TMO_CYC     = 32,
    parameter int FLT_CYC     = 250,
    parameter int HOLD_CYC    = 29,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_above_hi,
    input  logic       pwm_below_lo,
    input  logic       lgate_low,
    input  logic       swnode_low,
    input  logic       supply_ok,
    output logic       hs_gate_en,
    output logic       ls_gate_en,
    output logic [2:0] seq_status
);
    localparam int NFLAG = 5;

    logic [NFLAG-1:0] raw_flags, syn_flags;

    assign raw_flags = {supply_ok, swnode_low, lgate_low, pwm_below_lo, pwm_above_hi};

    hbd_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw_flags), .sync_out(syn_flags)
    );

    hbd_fsm #(.TMO_CYC(TMO_CYC), .FLT_CYC(FLT_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .above_s(syn_flags[0]),
        .below_s(syn_flags[1]),
        .lg_low_s(syn_flags[2]),
        .sw_low_s(syn_flags[3]),
        .sup_s(syn_flags[4]),
        .hs_en(hs_gate_en),
        .ls_en(ls_gate_en),
        .status(seq_status)
    );
endmodule

// File: tb/tb_hb_deadtime_seq.sv
`timescale 1ns/1ps
module tb_hb_deadtime_seq;
    localparam int TMO  = 5;
    localparam int FLT  = 12;
    localparam int HOLD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0, lg_low = 1'b0, sw_low = 1'b0, sup = 1'b0;
    logic hs, ls;
    logic [2:0] st;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hb_deadtime_seq #(.TMO_CYC(TMO), .FLT_CYC(FLT), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_above_hi(pwm_hi), .pwm_below_lo(pwm_lo),
        .lgate_low(lg_low), .swnode_low(sw_low), .supply_ok(sup),
        .hs_gate_en(hs), .ls_gate_en(ls), .seq_status(st)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // 0 = low command, 1 = high command, 2 = middle window
    task automatic set_pwm(int l);
        pwm_hi = (l == 1);
        pwm_lo = (l == 0);
    endtask

    task automatic go_upper();
        set_pwm(1); lg_low = 1'b1; step(6);
    endtask

    task automatic go_lower();
        set_pwm(0); sw_low = 1'b1; step(6);
    endtask

    function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction
    function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(2);
        chk("R1", "status in reset", st, 0);
        chk("R1", "hs in reset", hs, 0);
        chk("R1", "ls in reset", ls, 0);
        rst_n = 1'b1;
        set_pwm(1); lg_low = 1'b1;
        step(8);
        chk("R1", "status supply bad", st, 0);
        chk("R1", "hs supply bad", hs, 0);
        // R10 three-edge latency
        sup = 1'b1;
        step(2);
        chk("R10", "status before third edge", st, 0);
        step(1);
        chk("R10", "status waiting at third edge", st, 3);
        step(1);
        chk("R10", "status upper", st, 1);
        // R1 supply loss and recovery
        sup = 1'b0;
        step(2);
        chk("R1", "hs before loss visible", hs, 1);
        step(1);
        chk("R1", "hs after supply loss", hs, 0);
        chk("R1", "status after supply loss", st, 0);
        sup = 1'b1;
        step(3);
        chk("R1", "status resume wait", st, 3);
        step(1);
        chk("R1", "status resume upper", st, 1);

        // R2 rising sequence
        go_lower();
        lg_low = 1'b0; set_pwm(1);
        step(2);
        chk("R2", "ls before drop", ls, 1);
        step(1);
        chk("R2", "ls dropped first", ls, 0);
        chk("R2", "status waiting", st, 3);
        step(5);
        chk("R2", "hs held without lg flag", hs, 0);
        lg_low = 1'b1;
        step(2);
        chk("R2", "hs before flag visible", hs, 0);
        step(1);
        chk("R2", "hs after flag", hs, 1);

        // R3 falling sequence
        go_upper();
        sw_low = 1'b0; set_pwm(0);
        step(3);
        chk("R3", "hs dropped first", hs, 0);
        chk("R3", "ls waits for switch node", ls, 0);
        chk("R3", "status waiting", st, 3);
        sw_low = 1'b1;
        step(2);
        chk("R3", "ls before flag visible", ls, 0);
        step(1);
        chk("R3", "ls after flag", ls, 1);
        chk("R3", "status lower", st, 2);

        // R4 timeout sweep over switch-node delay
        for (int d = 0; d <= TMO + 3; d++) begin
            int first_ls, first_hs0;
            first_ls = -1; first_hs0 = -1;
            go_upper();
            sw_low = (d == 0); set_pwm(0);
            for (int i = 1; i <= 30; i++) begin
                step(1);
                if (ls && first_ls < 0) first_ls = i;
                if (!hs && first_hs0 < 0) first_hs0 = i;
                if (i == d) sw_low = 1'b1;
            end
            chk("R4", $sformatf("ls rise edge d=%0d", d), first_ls, imin(3 + TMO, imax(4, d + 3)));
            chk("R3", $sformatf("hs drop edge d=%0d", d), first_hs0, 3);
            chk("R4", $sformatf("final status d=%0d", d), st, 2);
        end

        // R5 fault entry and hold
        begin
            int first_flt, first_ls;
            first_flt = -1; first_ls = -1;
            go_upper();
            sw_low = 1'b0; set_pwm(0);
            for (int i = 1; i <= 40; i++) begin
                step(1);
                if (st == 3'd5 && first_flt < 0) first_flt = i;
                if (ls && first_ls < 0) first_ls = i;
            end
            chk("R4", "forced ls edge", first_ls, 3 + TMO);
            chk("R5", "fault entry edge", first_flt, 3 + TMO + FLT);
            chk("R5", "ls in fault", ls, 0);
            set_pwm(2); step(HOLD + 6);
            chk("R5", "middle window ignored in fault", st, 5);
            set_pwm(0); step(6);
            chk("R5", "low command ignored in fault", st, 5);
            sw_low = 1'b1; step(4);
            chk("R5", "switch node recovery ignored", st, 5);
            chk("R5", "ls still low", ls, 0);
            set_pwm(1); lg_low = 1'b1;
            step(3);
            chk("R5", "fault exit to wait", st, 3);
            step(1);
            chk("R5", "upper after fault", st, 1);
        end

        // R6 and R7 holdoff sweep
        for (int m = 1; m <= HOLD + 2; m++) begin
            int first_sh, last_sh;
            first_sh = -1; last_sh = -1;
            go_lower();
            set_pwm(2);
            for (int i = 1; i <= 20; i++) begin
                step(1);
                if (st == 3'd4) begin
                    if (first_sh < 0) first_sh = i;
                    last_sh = i;
                    chk("R6", "ls low in shutdown", ls, 0);
                end
                if (i == m) set_pwm(0);
            end
            chk("R6", $sformatf("shutdown entry m=%0d", m), first_sh, (m >= HOLD) ? 2 + HOLD : -1);
            chk("R7", $sformatf("shutdown exit m=%0d", m), last_sh, (m >= HOLD) ? m + 2 : -1);
            chk("R7", $sformatf("lower resumed m=%0d", m), st, 2);
        end
        go_upper();
        set_pwm(2); step(HOLD + 6);
        chk("R6", "shutdown from upper", st, 4);
        chk("R6", "hs low in shutdown", hs, 0);
        set_pwm(1);
        step(3);
        chk("R7", "exit high to wait", st, 3);
        step(1);
        chk("R7", "upper after shutdown", st, 1);

        // R8 reversal while waiting to turn on upper
        go_lower();
        lg_low = 1'b0; set_pwm(1);
        step(7);
        chk("R8", "waiting for lg flag", st, 3);
        set_pwm(0);
        step(3);
        chk("R8", "hs never raised", hs, 0);
        step(1);
        chk("R8", "lower after reversal", st, 2);
        // R8 reversal while waiting to turn on lower
        go_upper();
        sw_low = 1'b0; set_pwm(0);
        step(3);
        chk("R8", "down wait", st, 3);
        set_pwm(1);
        step(3);
        chk("R8", "ls never raised", ls, 0);
        chk("R8", "up wait after reversal", st, 3);
        step(1);
        chk("R8", "upper after reversal", st, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule